// File: doc/BRIEF.md
# Host-Fed Monochrome Color Expander

This unit sits behind the register data port of a 2D drawing engine. Once an operation has been set up and started, the host writes source bytes one at a time. In expansion mode each byte carries eight one-bit pixels. The unit turns every pixel into a colored write inside a destination rectangle in frame memory. A set bit paints the foreground color. A clear bit either paints the background color or is skipped, leaving the memory untouched. With expansion off, the same path copies raw host bytes into the rectangle as a pass-through.

Every source row the host sends is padded to a whole number of 4-byte words. The unit counts the data bytes and the pixels in each row. It consumes the padding bytes and drops them, and it moves the destination start address down by the programmed pitch after each row. When the final byte of the final row has been handled, the unit raises a one-cycle completion pulse and returns to idle. Host bytes are taken with a ready/valid handshake, because one expanded byte takes several cycles to paint.

Top module: `host_mono_expander`

## Requirements
- R1: Configuration registers are written through `reg_idx`/`reg_wdata` with `reg_we`. The index map is: 0x0/0x1 width in bytes minus one (low/high), 0x2/0x3 rows minus one (low/high), 0x4/0x5 destination pitch (low/high), 0x6/0x7/0x8 destination address (low/mid/high), 0x9 mode, 0xA/0xB foreground (low/high), 0xC/0xD background (low/high), 0xE bit 0 = start, 0xF bit 0 = two-byte pixels. A start write begins an operation only if the unit is idle and mode bit 1 (host source) is set. Otherwise it is ignored and `busy` stays low.
- R2: With mode bit 7 set (expansion), the bits of each data byte are taken most significant first, the MSB being the leftmost pixel. A one bit writes the foreground color at that pixel's address.
- R3: With expansion on, a zero bit writes the background color when mode bit 3 is clear. When mode bit 3 is set, a zero bit produces no write, but the pixel address still advances.
- R4: With two-byte pixels, a write carries the full 16-bit color with `wr_wide`=1 and pixels are 2 address units apart. With one-byte pixels, `wr_data` holds the color's low byte with bits 15:8 zero, `wr_wide`=0, and pixels are 1 unit apart.
- R5: In expansion mode a row has P pixels, where P is the width in bytes, halved for two-byte pixels. It is fed as ceil(P/8) data bytes plus padding up to a multiple of 4 bytes. Padding bytes and the unused trailing bits of the last data byte produce no write. With two-byte pixels, the width in bytes must be even.
- R6: With mode bit 7 clear, each row carries width-in-bytes raw bytes, padded to a multiple of 4. Each raw byte is written unchanged (`wr_wide`=0, bits 15:8 zero) to consecutive addresses. Padding is dropped.
- R7: Row r of the rectangle starts at destination address + r × pitch.
- R8: `done` pulses high for exactly one cycle when the last byte of the last row has been handled, and `busy` falls in that same cycle. If the final row ends on a data byte in expansion mode, `done` coincides with the write of that byte's last pixel.
- R9: When no operation is active, `hd_ready` stays low. A host byte offered then is neither consumed nor turned into a write.
- R10: During and after reset, `busy`, `hd_ready`, `wr_en` and `done` are low.
- R11: The configuration is captured at start. Register writes made while an operation runs, including a second start, do not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| hd_valid | input | 1 | Host offers a source byte |
| hd_byte | input | 8 | Host source byte |
| hd_ready | output | 1 | Unit takes the offered byte at this edge |
| busy | output | 1 | An operation is in progress |
| wr_en | output | 1 | Pixel or byte write strobe |
| wr_addr | output | AW | Destination byte address of the write |
| wr_data | output | 16 | Write data |
| wr_wide | output | 1 | 1 = two-byte write, 0 = single byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can fall in the same cycle are the final pixel write of a row and completion of the whole operation. This happens when a row's data bytes exactly fill the 4-byte multiple, so no padding follows. The bench provokes this case with a 32-pixel-wide rectangle and contrasts it with padded shapes, where `done` must come with no write beside it. Every write is compared against a queue built from the rules above, and a host byte offered right after completion must stay unconsumed.

// File: rtl/cex_pkg.sv
package cex_pkg;

  // configuration register indices
  localparam logic [3:0] IDX_WID_LO  = 4'h0;
  localparam logic [3:0] IDX_WID_HI  = 4'h1;
  localparam logic [3:0] IDX_ROW_LO  = 4'h2;
  localparam logic [3:0] IDX_ROW_HI  = 4'h3;
  localparam logic [3:0] IDX_PIT_LO  = 4'h4;
  localparam logic [3:0] IDX_PIT_HI  = 4'h5;
  localparam logic [3:0] IDX_DST_LO  = 4'h6;
  localparam logic [3:0] IDX_DST_MID = 4'h7;
  localparam logic [3:0] IDX_DST_HI  = 4'h8;
  localparam logic [3:0] IDX_MODE    = 4'h9;
  localparam logic [3:0] IDX_FG_LO   = 4'hA;
  localparam logic [3:0] IDX_FG_HI   = 4'hB;
  localparam logic [3:0] IDX_BG_LO   = 4'hC;
  localparam logic [3:0] IDX_BG_HI   = 4'hD;
  localparam logic [3:0] IDX_CTRL    = 4'hE;
  localparam logic [3:0] IDX_DEPTH   = 4'hF;

  // mode register bit positions
  localparam int MB_HOST   = 1;
  localparam int MB_TRANSP = 3;
  localparam int MB_EXPAND = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_SHIFT = 2'd2
  } cex_state_e;

endpackage

// File: rtl/cex_cfg_regs.sv
module cex_cfg_regs
  import cex_pkg::*;
#(
  parameter int WW = 13,
  parameter int HW = 11,
  parameter int PW = 13,
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [3:0]    reg_idx,
  input  logic [7:0]    reg_wdata,
  output logic [WW-1:0] width_m1,
  output logic [HW-1:0] rows_m1,
  output logic [PW-1:0] pitch,
  output logic [AW-1:0] dst_base,
  output logic          md_expand,
  output logic          md_host,
  output logic          md_transp,
  output logic [15:0]   fg_color,
  output logic [15:0]   bg_color,
  output logic          wide_px,
  output logic          start_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_m1  <= '0;
      rows_m1   <= '0;
      pitch     <= '0;
      dst_base  <= '0;
      md_expand <= 1'b0;
      md_host   <= 1'b0;
      md_transp <= 1'b0;
      fg_color  <= '0;
      bg_color  <= '0;
      wide_px   <= 1'b0;
    end else if (reg_we) begin
      case (reg_idx)
        IDX_WID_LO:  width_m1[7:0]     <= reg_wdata;
        IDX_WID_HI:  width_m1[WW-1:8]  <= reg_wdata[WW-9:0];
        IDX_ROW_LO:  rows_m1[7:0]      <= reg_wdata;
        IDX_ROW_HI:  rows_m1[HW-1:8]   <= reg_wdata[HW-9:0];
        IDX_PIT_LO:  pitch[7:0]        <= reg_wdata;
        IDX_PIT_HI:  pitch[PW-1:8]     <= reg_wdata[PW-9:0];
        IDX_DST_LO:  dst_base[7:0]     <= reg_wdata;
        IDX_DST_MID: dst_base[15:8]    <= reg_wdata;
        IDX_DST_HI:  dst_base[AW-1:16] <= reg_wdata[AW-17:0];
        IDX_MODE: begin
          md_expand <= reg_wdata[MB_EXPAND];
          md_host   <= reg_wdata[MB_HOST];
          md_transp <= reg_wdata[MB_TRANSP];
        end
        IDX_FG_LO:   fg_color[7:0]     <= reg_wdata;
        IDX_FG_HI:   fg_color[15:8]    <= reg_wdata;
        IDX_BG_LO:   bg_color[7:0]     <= reg_wdata;
        IDX_BG_HI:   bg_color[15:8]    <= reg_wdata;
        IDX_DEPTH:   wide_px           <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // start is a strobe, never stored
  assign start_req = reg_we && (reg_idx == IDX_CTRL) && reg_wdata[0];

endmodule

// File: rtl/cex_row_geom.sv
module cex_row_geom #(
  parameter int WW = 13
) (
  input  logic [WW-1:0] width_m1,
  input  logic          wide_px,
  input  logic          expand,
  output logic [WW+1:0] data_bytes,
  output logic [WW+1:0] pad_bytes,
  output logic [WW+1:0] pix_count
);

  localparam int CW = WW + 2;

  logic [CW-1:0] wbytes;
  logic [CW-1:0] pix;
  logic [CW-1:0] dat;

  assign wbytes     = {2'b00, width_m1} + CW'(1);
  assign pix        = wide_px ? (wbytes >> 1) : wbytes;
  assign dat        = expand ? ((pix + CW'(7)) >> 3) : wbytes;
  assign data_bytes = dat;
  assign pad_bytes  = (dat + CW'(3)) & ~CW'(3);
  assign pix_count  = pix;

endmodule

// File: rtl/cex_bit_shifter.sv
module cex_bit_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic [3:0] load_cnt,
  output logic       bit_msb,
  output logic       last
);

  logic [7:0] sr;
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= load_byte;
      cnt <= load_cnt;
    end else if (cnt != 4'd0) begin
      sr  <= {sr[6:0], 1'b0};
      cnt <= cnt - 4'd1;
    end
  end

  assign bit_msb = sr[7];
  assign last    = (cnt == 4'd1);

endmodule

// File: rtl/host_mono_expander.sv
module host_mono_expander
  import cex_pkg::*;
#(
  parameter int WW = 13,
  parameter int HW = 11,
  parameter int PW = 13,
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [3:0]    reg_idx,
  input  logic [7:0]    reg_wdata,
  input  logic          hd_valid,
  input  logic [7:0]    hd_byte,
  output logic          hd_ready,
  output logic          busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          wr_wide,
  output logic          done
);

  localparam int CW = WW + 2;

  // live configuration
  logic [WW-1:0] cfg_width_m1;
  logic [HW-1:0] cfg_rows_m1;
  logic [PW-1:0] cfg_pitch;
  logic [AW-1:0] cfg_dst;
  logic          cfg_expand, cfg_host, cfg_transp, cfg_wide, start_req;
  logic [15:0]   cfg_fg, cfg_bg;
  logic [CW-1:0] g_data, g_pad, g_pix;

  cex_cfg_regs #(.WW(WW), .HW(HW), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .width_m1(cfg_width_m1), .rows_m1(cfg_rows_m1), .pitch(cfg_pitch), .dst_base(cfg_dst),
    .md_expand(cfg_expand), .md_host(cfg_host), .md_transp(cfg_transp),
    .fg_color(cfg_fg), .bg_color(cfg_bg), .wide_px(cfg_wide), .start_req(start_req)
  );

  cex_row_geom #(.WW(WW)) u_geom (
    .width_m1(cfg_width_m1), .wide_px(cfg_wide), .expand(cfg_expand),
    .data_bytes(g_data), .pad_bytes(g_pad), .pix_count(g_pix)
  );

  // operation state, captured at start
  cex_state_e    st;
  logic [CW-1:0] l_data, l_pad, l_pix;
  logic [HW-1:0] l_rows;
  logic [PW-1:0] l_pitch;
  logic          l_expand, l_transp, l_wide;
  logic [15:0]   l_fg, l_bg;
  logic [CW-1:0] byte_cnt, pix_left;
  logic [HW-1:0] row_cnt;
  logic [AW-1:0] row_addr, cur_addr;
  logic          row_end_pend;

  // bit serializer
  logic       sh_load, sh_bit, sh_last;
  logic [3:0] n_bits;

  cex_bit_shifter u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_byte(hd_byte), .load_cnt(n_bits),
    .bit_msb(sh_bit), .last(sh_last)
  );

  logic          take, is_data, at_row_end, raw_emit, px_emit, close_row, last_row;
  logic [AW-1:0] next_row_addr, px_step;
  logic [15:0]   px_color, px_data;

  always_comb begin
    take          = (st == ST_FEED) && hd_valid;
    is_data       = byte_cnt < l_data;
    at_row_end    = byte_cnt == (l_pad - CW'(1));
    n_bits        = (pix_left >= CW'(8)) ? 4'd8 : pix_left[3:0];
    sh_load       = take && is_data && l_expand;
    raw_emit      = take && is_data && !l_expand;
    px_emit       = (st == ST_SHIFT) && (sh_bit || !l_transp);
    close_row     = (take && at_row_end && !sh_load) ||
                    ((st == ST_SHIFT) && sh_last && row_end_pend);
    last_row      = row_cnt == l_rows;
    next_row_addr = row_addr + AW'(l_pitch);
    px_step       = l_wide ? AW'(2) : AW'(1);
    px_color      = sh_bit ? l_fg : l_bg;
    px_data       = l_wide ? px_color : {8'h00, px_color[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      l_data       <= '0;
      l_pad        <= '0;
      l_pix        <= '0;
      l_rows       <= '0;
      l_pitch      <= '0;
      l_expand     <= 1'b0;
      l_transp     <= 1'b0;
      l_wide       <= 1'b0;
      l_fg         <= '0;
      l_bg         <= '0;
      byte_cnt     <= '0;
      pix_left     <= '0;
      row_cnt      <= '0;
      row_addr     <= '0;
      cur_addr     <= '0;
      row_end_pend <= 1'b0;
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      wr_wide      <= 1'b0;
      done         <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_req && cfg_host) begin
            l_data   <= g_data;
            l_pad    <= g_pad;
            l_pix    <= g_pix;
            l_rows   <= cfg_rows_m1;
            l_pitch  <= cfg_pitch;
            l_expand <= cfg_expand;
            l_transp <= cfg_transp;
            l_wide   <= cfg_wide;
            l_fg     <= cfg_fg;
            l_bg     <= cfg_bg;
            byte_cnt <= '0;
            pix_left <= g_pix;
            row_cnt  <= '0;
            row_addr <= cfg_dst;
            cur_addr <= cfg_dst;
            st       <= ST_FEED;
          end
        end
        ST_FEED: begin
          if (take) begin
            byte_cnt <= byte_cnt + CW'(1);
          end
          if (raw_emit) begin
            wr_en    <= 1'b1;
            wr_addr  <= cur_addr;
            wr_data  <= {8'h00, hd_byte};
            wr_wide  <= 1'b0;
            cur_addr <= cur_addr + AW'(1);
          end
          if (sh_load) begin
            pix_left     <= pix_left - CW'(n_bits);
            row_end_pend <= at_row_end;
            st           <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (px_emit) begin
            wr_en   <= 1'b1;
            wr_addr <= cur_addr;
            wr_data <= px_data;
            wr_wide <= l_wide;
          end
          cur_addr <= cur_addr + px_step;
          if (sh_last) begin
            st <= ST_FEED;
          end
        end
        default: st <= ST_IDLE;
      endcase
      // row completion overrides the per-state updates
      if (close_row) begin
        byte_cnt <= '0;
        pix_left <= l_pix;
        row_addr <= next_row_addr;
        cur_addr <= next_row_addr;
        if (last_row) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else begin
          row_cnt <= row_cnt + HW'(1);
          st      <= ST_FEED;
        end
      end
    end
  end

  assign busy     = (st != ST_IDLE);
  assign hd_ready = (st == ST_FEED);

endmodule

// File: rtl/cex_checker.sv
module cex_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [15:0] wr_data,
  input logic        done
);

  AST_WRITE_NEEDS_ENGINE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy)); // R9

  AST_START_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wr_en); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide) |-> (wr_data[15:8] == 8'h00)); // R4

endmodule

bind host_mono_expander cex_checker u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wr_en(wr_en),
  .wr_wide(wr_wide), .wr_data(wr_data), .done(done)
);

// File: tb/sim_host_mono_expander.sv
module sim_host_mono_expander;

  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_we;
  logic [3:0]    reg_idx;
  logic [7:0]    reg_wdata;
  logic          hd_valid;
  logic [7:0]    hd_byte;
  logic          hd_ready, busy, wr_en, wr_wide, done;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  always #10 clk = ~clk;

  host_mono_expander u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .hd_valid(hd_valid), .hd_byte(hd_byte), .hd_ready(hd_ready), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide), .done(done)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [15:0]   d;
    logic          w;
  } wr_t;

  wr_t   exp_q[$];
  wr_t   mon_e;
  int    n_checks = 0;
  int    n_fail   = 0;
  int    writes_seen = 0;
  int    dones = 0;
  bit    done_with_write = 1'b0;
  string cur_req = "R10";

  task automatic check(string req, bit ok, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard as writes appear
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        writes_seen++;
        if (exp_q.size() == 0) begin
          check(cur_req, 1'b0, "unexpected write addr", longint'(wr_addr), 0);
        end else begin
          mon_e = exp_q.pop_front();
          check(cur_req, (wr_addr == mon_e.a) && (wr_data == mon_e.d) && (wr_wide == mon_e.w),
                "write {addr,data,wide}", longint'({wr_addr, wr_data, wr_wide}), longint'(mon_e));
        end
      end
      if (done) begin
        dones++;
        done_with_write = wr_en;
      end
    end
  end

  function automatic logic [7:0] pat(int seed, int r, int i);
    return 8'(seed * 13 + r * 29 + i * 83 + i * i);
  endfunction

  task automatic wreg(int idx, int val);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_idx   = 4'(idx);
    reg_wdata = 8'(val);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic send_byte(string req, logic [7:0] b);
    int k;
    hd_valid = 1'b1;
    hd_byte  = b;
    for (k = 0; k < 50; k++) begin
      if (hd_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    if (k >= 50) check(req, 1'b0, "byte never taken", 0, 1);
  endtask

  // offer bytes while idle: none may be taken or written
  task automatic idle_offer(string req);
    int ready_seen = 0;
    int w0 = writes_seen;
    hd_valid = 1'b1;
    hd_byte  = 8'hFF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (hd_ready) ready_seen++;
    end
    hd_valid = 1'b0;
    check(req, ready_seen == 0, "hd_ready while idle", ready_seen, 0);
    check(req, writes_seen == w0, "writes while idle", writes_seen - w0, 0);
  endtask

  task automatic run_op(string req, int wm1, int rm1, int pitch, int dst, bit ex, bit tr,
                        bit wide, int fg, int bg, int seed, bit disturb);
    int W  = wm1 + 1;
    int P  = wide ? W / 2 : W;
    int SB = ex ? (P + 7) / 8 : W;
    int PB = ((SB + 3) / 4) * 4;
    int st = wide ? 2 : 1;
    int d0 = dones;
    int k;
    cur_req = req;
    for (int r = 0; r <= rm1; r++) begin
      int base = dst + r * pitch;
      if (ex) begin
        for (int j = 0; j < P; j++) begin
          logic [7:0] b  = pat(seed, r, j / 8);
          logic       bt = b[7 - (j % 8)];
          int         c  = bt ? fg : bg;
          wr_t        e;
          if (bt || !tr) begin
            e.a = AW'(base + j * st);
            e.d = wide ? 16'(c) : {8'h00, 8'(c)};
            e.w = wide;
            exp_q.push_back(e);
          end
        end
      end else begin
        for (int i = 0; i < W; i++) begin
          wr_t e;
          e.a = AW'(base + i);
          e.d = {8'h00, pat(seed, r, i)};
          e.w = 1'b0;
          exp_q.push_back(e);
        end
      end
    end
    wreg(0, wm1 & 8'hFF);   wreg(1, wm1 >> 8);
    wreg(2, rm1 & 8'hFF);   wreg(3, rm1 >> 8);
    wreg(4, pitch & 8'hFF); wreg(5, pitch >> 8);
    wreg(6, dst & 8'hFF);   wreg(7, (dst >> 8) & 8'hFF); wreg(8, dst >> 16);
    wreg(9, (ex ? 8'h80 : 0) | (tr ? 8'h08 : 0) | 8'h02);
    wreg(10, fg & 8'hFF);   wreg(11, (fg >> 8) & 8'hFF);
    wreg(12, bg & 8'hFF);   wreg(13, (bg >> 8) & 8'hFF);
    wreg(15, wide ? 1 : 0);
    wreg(14, 1);
    check("R1", busy == 1'b1, "busy after start", busy, 1);
    if (disturb) begin
      // R11: new colors and a second start during the operation
      wreg(10, ~fg & 8'hFF); wreg(11, (~fg >> 8) & 8'hFF);
      wreg(12, ~bg & 8'hFF); wreg(14, 1);
    end
    for (int r = 0; r <= rm1; r++)
      for (int i = 0; i < PB; i++)
        send_byte(req, (i < SB) ? pat(seed, r, i) : 8'hFF);
    hd_valid = 1'b0;
    for (k = 0; k < 60 && busy; k++) @(negedge clk);
    @(negedge clk);
    check("R8", dones == d0 + 1, "done pulses", dones - d0, 1);
    check("R8", busy == 1'b0, "busy after done", busy, 0);
    check(req, exp_q.size() == 0, "writes missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
    hd_valid = 1'b0; hd_byte = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {busy, hd_ready, wr_en, done} == 4'b0, "outputs in reset",
          longint'({busy, hd_ready, wr_en, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", {busy, hd_ready, wr_en, done} == 4'b0, "outputs after reset",
          longint'({busy, hd_ready, wr_en, done}), 0);

    // R9: host bytes while idle
    idle_offer("R9");

    // R1: start with host source clear is ignored
    wreg(9, 8'h80);
    wreg(14, 1);
    repeat (3) @(negedge clk);
    check("R1", busy == 1'b0, "busy without host source", busy, 0);

    // R2 R3 R5: narrow, opaque, 11 pixels -> 2 data + 2 pad bytes
    run_op("R2", 10, 2, 64, 'h100, 1, 0, 0, 'hA55A, 'h1234, 1, 0);
    check("R8", done_with_write == 1'b0, "done beside write after padding", done_with_write, 0);

    // R3 R4 R7: wide, transparent, 20 pixels, pitch 200
    run_op("R3", 39, 1, 200, 'h2_0000, 1, 1, 1, 'hBEEF, 'h0F0F, 5, 0);

    // R4 R7: wide, opaque, 7 pixels, three rows
    run_op("R4", 13, 2, 40, 'h3F_FF00, 1, 0, 1, 'h8001, 'h7E7E, 9, 0);

    // R8: 32 pixels, row ends on a data byte, done with last write
    run_op("R8", 31, 1, 48, 'h400, 1, 0, 0, 'h00C3, 'h003C, 3, 0);
    check("R8", done_with_write == 1'b1, "done beside final write", done_with_write, 1);

    // R5: single pixel rows, heavy padding
    run_op("R5", 0, 3, 16, 'h50, 1, 0, 0, 'h0011, 'h0022, 7, 0);

    // R6: raw pass-through, 5 bytes padded to 8
    run_op("R6", 4, 1, 32, 'h800, 0, 0, 0, 0, 0, 11, 0);

    // R11: register writes during the operation are ignored
    run_op("R11", 17, 1, 64, 'h1000, 1, 0, 0, 'h0033, 'h00CC, 2, 1);

    // R8 R9: nothing taken after completion
    idle_offer("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule